// File: doc/BRIEF.md
# Input Capture Cell with Selectable Clock

This cell sits between one input pin and the logic array. It hands the pin value to the array in one of three ways. In bypass mode the value goes straight through. In register mode the value is stored on a rising edge of the capture clock. In latch mode the stored value follows the pin while the capture clock is high and freezes while the clock is low.

The capture clock is picked from three sources: dedicated clock pin A, dedicated clock pin B, or a clock produced by the logic array. An invert control can flip the picked clock, so that a register captures on the falling edge of the source and a latch is open while the source is low. The flipped result is called the effective clock.

All clock sources are treated as level signals and are sampled on the core clock `clk`. A two-state phase tracker follows the effective clock:
- States: `PH_LOW` and `PH_HIGH`.
- Transition `ROSE` goes from `PH_LOW` to `PH_HIGH` when the effective clock is sampled high. A register-mode capture happens on this transition.
- Transition `FELL` goes from `PH_HIGH` to `PH_LOW` when the effective clock is sampled low.
- Each state holds for as long as the effective clock level agrees with it.
- Reset puts the tracker in `PH_LOW`.

Top module: `incap_cell`

## Requirements
- R1: While the active-low reset `rst_n` is low, the stored value is 0. In register mode the output is therefore 0.
- R2: In register mode (`cfg_mode` = 2'b01), the output shows the stored value. The stored value takes `pin_d` only at a core edge where the effective clock is sampled high and was sampled low at the previous core edge. At every other core edge it holds.
- R3: In latch mode (`cfg_mode` = 2'b10), while the effective clock is high the output equals `pin_d` in the same cycle. Changes in `pin_d` during that time pass through.
- R4: In latch mode, while the effective clock is low, the output holds the `pin_d` value taken at the last core edge where the effective clock was sampled high in latch mode.
- R5: With `cfg_mode` = 2'b00 or 2'b11 (bypass), the output equals `pin_d` with no storage.
- R6: The clock source is selected by `cfg_src`: 2'b00 selects `ck_pin_a`, 2'b01 selects `ck_pin_b`, and 2'b10 selects `ck_array`. The reserved code 2'b11 falls back to `ck_pin_a`.
- R7: With `cfg_invert` = 1, the effective clock is the inverse of the selected source. A register then captures on the source's falling edge, and a latch is open while the source is low.
- R8: After reset the phase tracker is in `PH_LOW`. An effective clock that is already high at the first core edge after release therefore counts as a rising edge and captures.
- R9: Bypass mode leaves the stored value untouched, whatever the clocks do. The value seen on return to register mode, with no new rising edge, is the value stored before the bypass interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples the clock sources |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_d | input | DATA_W | Pin value to be captured |
| ck_pin_a | input | 1 | Dedicated clock pin A |
| ck_pin_b | input | 1 | Dedicated clock pin B |
| ck_array | input | 1 | Clock generated by the logic array |
| cfg_mode | input | 2 | 00 bypass, 01 register, 10 latch, 11 bypass |
| cfg_src | input | 2 | Clock source select: 00 pin A, 01 pin B, 10 array, 11 pin A |
| cfg_invert | input | 1 | 1 inverts the selected clock |
| array_in | output | DATA_W | Value presented to the logic array |

## Verification
Two things can happen in the same core cycle: a new `pin_d` value and a change of the effective clock.

The bench provokes this by toggling the clock sources at random and changing the data in every cycle. Many latch closings and register rising edges therefore coincide with a data change.

A behavioural reference model decides, cycle by cycle, whether the value taken is the one present at the sampling edge. Its verdict is compared with `array_in` on every clock, for every mode, every source code and both polarities.

// File: rtl/incap_pkg.sv
package incap_pkg;

    typedef enum logic [1:0] {
        MD_BYPASS = 2'b00,
        MD_FLOP   = 2'b01,
        MD_LATCH  = 2'b10,
        MD_RSVD   = 2'b11
    } cap_mode_e;

    typedef enum logic [1:0] {
        SRC_PIN_A = 2'b00,
        SRC_PIN_B = 2'b01,
        SRC_GEN   = 2'b10,
        SRC_RSVD  = 2'b11
    } clk_src_e;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

endpackage

// File: rtl/incap_clk_sel.sv
module incap_clk_sel
    import incap_pkg::*;
(
    input  logic     ck_a,
    input  logic     ck_b,
    input  logic     ck_gen,
    input  clk_src_e src,
    input  logic     invert,
    output logic     eff
);

    logic picked;

    always_comb begin
        unique case (src)
            SRC_PIN_B: picked = ck_b;
            SRC_GEN:   picked = ck_gen;
            default:   picked = ck_a;   // pin A and reserved code
        endcase
    end

    assign eff = picked ^ invert;

endmodule

// File: rtl/incap_phase.sv
module incap_phase
    import incap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eff,
    output logic rise
);

    phase_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            PH_LOW:  state_d = eff ? PH_HIGH : PH_LOW;   // ROSE
            PH_HIGH: state_d = eff ? PH_HIGH : PH_LOW;   // FELL
            default: state_d = PH_LOW;
        endcase
    end

    always_comb begin
        unique case (state_q)
            PH_LOW:  rise = eff;
            default: rise = 1'b0;
        endcase
    end

endmodule

// File: rtl/incap_store.sv
module incap_store
    import incap_pkg::*;
#(
    parameter int DATA_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cap_mode_e         mode,
    input  logic              eff,
    input  logic              rise,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] held
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
        end else begin
            unique case (mode)
                MD_FLOP:  if (rise) held <= d;
                MD_LATCH: if (eff)  held <= d;
                default:  held <= held;
            endcase
        end
    end

endmodule

// File: rtl/incap_cell.sv
module incap_cell
    import incap_pkg::*;
#(
    parameter int DATA_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pin_d,
    input  logic              ck_pin_a,
    input  logic              ck_pin_b,
    input  logic              ck_array,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_src,
    input  logic              cfg_invert,
    output logic [DATA_W-1:0] array_in
);

    cap_mode_e         mode;
    logic              eff;
    logic              rise;
    logic [DATA_W-1:0] held;

    assign mode = cap_mode_e'(cfg_mode);

    incap_clk_sel u_sel (
        .ck_a   (ck_pin_a),
        .ck_b   (ck_pin_b),
        .ck_gen (ck_array),
        .src    (clk_src_e'(cfg_src)),
        .invert (cfg_invert),
        .eff    (eff)
    );

    incap_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .eff   (eff),
        .rise  (rise)
    );

    incap_store #(.DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .eff   (eff),
        .rise  (rise),
        .d     (pin_d),
        .held  (held)
    );

    always_comb begin
        unique case (mode)
            MD_FLOP:  array_in = held;
            MD_LATCH: array_in = eff ? pin_d : held;
            default:  array_in = pin_d;
        endcase
    end

endmodule

// File: rtl/incap_cell_chk.sv
module incap_cell_chk #(
    parameter int DATA_W = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] pin_d,
    input logic              ck_pin_a,
    input logic              ck_pin_b,
    input logic              ck_array,
    input logic [1:0]        cfg_mode,
    input logic [1:0]        cfg_src,
    input logic              cfg_invert,
    input logic [DATA_W-1:0] array_in
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        (!rst_n && cfg_mode == 2'b01) |-> array_in == '0); // R1

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b00 || cfg_mode == 2'b11) |-> array_in == pin_d); // R5

    AST_FLOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cfg_mode == 2'b01 && $stable(cfg_src) && $stable(cfg_invert)
         && $stable(ck_pin_a) && $stable(ck_pin_b) && $stable(ck_array))
        |=> (cfg_mode != 2'b01 || $stable(array_in))); // R2

    AST_LATCH_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b10 && cfg_src == 2'b00 && !cfg_invert && ck_pin_a)
        |-> array_in == pin_d); // R3

    AST_LATCH_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cfg_mode == 2'b10 && $past(cfg_mode) == 2'b10
         && cfg_src == 2'b00 && $past(cfg_src) == 2'b00
         && !cfg_invert && !$past(cfg_invert) && !ck_pin_a && !$past(ck_pin_a))
        |-> $stable(array_in)); // R4

    AST_LATCH_INV_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b10 && cfg_src == 2'b01 && cfg_invert && !ck_pin_b)
        |-> array_in == pin_d); // R7

endmodule

bind incap_cell incap_cell_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_d      (pin_d),
    .ck_pin_a   (ck_pin_a),
    .ck_pin_b   (ck_pin_b),
    .ck_array   (ck_array),
    .cfg_mode   (cfg_mode),
    .cfg_src    (cfg_src),
    .cfg_invert (cfg_invert),
    .array_in   (array_in)
);

// File: tb/incap_cell_test.sv
`timescale 1ns/1ps
module incap_cell_test;

    localparam int W = 1;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] pin_d;
    logic         ck_pin_a, ck_pin_b, ck_array;
    logic [1:0]   cfg_mode, cfg_src;
    logic         cfg_invert;
    logic [W-1:0] array_in;

    int compared   = 0;
    int mismatched = 0;

    // reference state
    logic [W-1:0] m_held;
    bit           m_prev;

    always #4 clk = ~clk;   // 125 MHz

    incap_cell #(.DATA_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .pin_d(pin_d),
        .ck_pin_a(ck_pin_a), .ck_pin_b(ck_pin_b), .ck_array(ck_array),
        .cfg_mode(cfg_mode), .cfg_src(cfg_src), .cfg_invert(cfg_invert),
        .array_in(array_in)
    );

    function automatic bit ref_eff();
        bit s;
        case (cfg_src)
            2'd1:    s = ck_pin_b;
            2'd2:    s = ck_array;
            default: s = ck_pin_a;
        endcase
        return s ^ cfg_invert;
    endfunction

    function automatic logic [W-1:0] ref_out();
        if (cfg_mode == 2'd1) return m_held;
        if (cfg_mode == 2'd2) return ref_eff() ? pin_d : m_held;
        return pin_d;
    endfunction

    task automatic model_edge();
        bit e;
        e = ref_eff();
        if (!rst_n) begin
            m_held = '0;
            m_prev = 1'b0;
        end else begin
            if (cfg_mode == 2'd1 && e && !m_prev) m_held = pin_d;
            if (cfg_mode == 2'd2 && e)            m_held = pin_d;
            m_prev = e;
        end
    endtask

    task automatic check(input string tag);
        logic [W-1:0] exp;
        #1;
        exp = ref_out();
        compared++;
        if (array_in !== exp) begin
            mismatched++;
            $display("FAIL %s: array_in=%0h expected=%0h (mode=%0d src=%0d inv=%0d)",
                     tag, array_in, exp, cfg_mode, cfg_src, cfg_invert);
        end
    endtask

    task automatic cycle(input string tag);
        check(tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    function automatic string tag_for();
        if (cfg_mode == 2'd1) return "R2/R6/R7";
        if (cfg_mode == 2'd2) return ref_eff() ? "R3/R6/R7" : "R4/R6/R7";
        return "R5";
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        m_held = '0; m_prev = 1'b0;
        rst_n = 1'b0; pin_d = '1;
        ck_pin_a = 1'b1; ck_pin_b = 1'b0; ck_array = 1'b0;
        cfg_mode = 2'd1; cfg_src = 2'd0; cfg_invert = 1'b0;
        @(negedge clk);
        cycle("R1");
        cycle("R1");
        // release with effective clock already high: first edge captures
        rst_n = 1'b1;
        cycle("R8");
        if (array_in !== 1'b1) begin
            mismatched++;
            $display("FAIL R8: array_in=%0h expected=1", array_in);
        end
        compared++;

        // sweep every mode, source code and polarity with random activity
        for (int md = 0; md < 4; md++) begin
            for (int sr = 0; sr < 4; sr++) begin
                for (int iv = 0; iv < 2; iv++) begin
                    cfg_mode = 2'(md); cfg_src = 2'(sr); cfg_invert = iv[0];
                    for (int k = 0; k < 24; k++) begin
                        if ($urandom % 3 == 0) ck_pin_a = ~ck_pin_a;
                        if ($urandom % 3 == 0) ck_pin_b = ~ck_pin_b;
                        if ($urandom % 3 == 0) ck_array = ~ck_array;
                        pin_d = W'($urandom);
                        cycle(tag_for());
                    end
                end
            end
        end

        // R9: bypass leaves stored value alone
        cfg_mode = 2'd1; cfg_src = 2'd0; cfg_invert = 1'b0;
        ck_pin_a = 1'b0; pin_d = 1'b1; cycle("R2");
        ck_pin_a = 1'b1; cycle("R2");
        ck_pin_a = 1'b0; pin_d = 1'b0; cycle("R2");
        cfg_mode = 2'd0;
        for (int k = 0; k < 10; k++) begin
            ck_pin_a = ~ck_pin_a;
            pin_d = W'($urandom);
            cycle("R5");
        end
        ck_pin_a = 1'b0;
        cycle("R5");
        cfg_mode = 2'd1; pin_d = 1'b0;
        cycle("R9");
        compared++;
        if (array_in !== 1'b1) begin
            mismatched++;
            $display("FAIL R9: array_in=%0h expected=1", array_in);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule